// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block gives two independent ports a bank of eight binary lock tokens. Each port has its own select, read/write, output-enable, 3-bit index and 8-bit data signals. A port asks for a token by writing a zero to it and gives it back by writing a one. Only bit 0 of the write data is used. A read returns the flag as that port sees it, copied onto every data bit. A flag of zero means "this port holds the token" and a flag of one means "this port does not hold it".

Each token keeps one request latch per side. A side that does not hold the token can still write a zero. That zero is kept in its latch as a pending request, and the token passes to that side on the same clock edge that the holder releases it. When both sides ask for a free token in the same cycle, the left port wins.

A read samples the flag once, at the edge where the read opens. The returned value then stays frozen until the port drops its token select or output enable, so a polling loop must close and reopen its read to see a change. The token bank is selected only when the memory select input is high and the token select input is low. Driving both selects low at once is an illegal access: nothing is written and nothing is read.

Top module: `sem_bank`

## Requirements
- R1: The 3-bit index selects one of eight tokens (0 to 7). An access to one index never changes the flags of any other index.
- R2: A zero written to a free token hands that token to the writing side. From the next clock edge on, that side reads 0x00 for it and the opposite side reads 0xFF.
- R3: While one side holds a token, a zero written by the other side does not take the token. A one written by the non-holder does not release it. At no time do both sides read a token as held (0x00).
- R4: A zero written by the non-holder is kept as a pending request. When the holder writes a one, the token passes to the pending side on that same edge.
- R5: A write uses only bit 0 of the write data, so 0xFE requests and 0x01 releases. A read drives the flag onto all eight bits: 0xFF for one and 0x00 for zero.
- R6: A read is open while `*_ram_sel_n`=1, `*_tok_sel_n`=0, `*_rnw`=1 and `*_out_en_n`=0. On the first edge of an open read, the flag of the indexed token (as it was before that edge) is captured and `*_rvalid` goes high. The captured value does not change while the read stays open. `*_rvalid` falls on the edge after the read closes, and while `*_rvalid` is low `*_rdata` is 0x00.
- R7: If both sides write a zero to the same free token in the same cycle, the left side gets it.
- R8: A token becomes free (reads 0xFF on both sides) only once both request latches hold a one. If the holder releases while the other side is pending, the token passes across and does not become free.
- R9: An access with `*_ram_sel_n`=0 and `*_tok_sel_n`=0 at the same time is ignored. It changes no flag and opens no read.
- R10: After a synchronous active-low reset, every token is free on both sides and both `*_rvalid` outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_ram_sel_n | input | 1 | Left memory select, active low; must be high for token access |
| l_tok_sel_n | input | 1 | Left token select, active low |
| l_rnw | input | 1 | Left direction: 1 read, 0 write |
| l_out_en_n | input | 1 | Left output enable, active low |
| l_idx | input | 3 | Left token index |
| l_wdata | input | 8 | Left write data (bit 0 used) |
| l_rdata | output | 8 | Left read data, held flag replicated |
| l_rvalid | output | 1 | Left read data valid |
| r_ram_sel_n | input | 1 | Right memory select, active low; must be high for token access |
| r_tok_sel_n | input | 1 | Right token select, active low |
| r_rnw | input | 1 | Right direction: 1 read, 0 write |
| r_out_en_n | input | 1 | Right output enable, active low |
| r_idx | input | 3 | Right token index |
| r_wdata | input | 8 | Right write data (bit 0 used) |
| r_rdata | output | 8 | Right read data, held flag replicated |
| r_rvalid | output | 1 | Right read data valid |

## Verification
A write changes the token state at the clock edge where it is driven. Its effect can first be seen by a read that opens after that edge. A read captures the flag at its first edge, and `*_rdata` and `*_rvalid` show the result one clock after the read is driven. `*_rvalid` falls one clock after the read closes. The bench drives inputs on the falling edge and samples one full period later, on the next falling edge, so each check lands on the first cycle where the result is due. The hold case keeps a read open across a handover of the token and confirms that the captured byte does not follow the change.

// File: rtl/sem_bank_pkg.sv
// Package: shared types for the two-port token bank.
// Assumes: none beyond standard SystemVerilog.
package sem_bank_pkg;

    // Which side currently holds a token.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Decoded intent of one port in the current cycle.
    typedef struct packed {
        logic wr;      // token write strobe
        logic rd_win;  // read window open
    } port_acc_t;

endpackage

// File: rtl/sem_port_decode.sv
// Module: sem_port_decode
// Turns one port's select, direction and enable pins into a token write strobe
// and a read-window level. An access with both selects low is illegal and
// gives neither.
// Assumes: all inputs are synchronous to the bank clock.
module sem_port_decode
    import sem_bank_pkg::*;
(
    input  logic      ram_sel_n,
    input  logic      tok_sel_n,
    input  logic      rnw,
    input  logic      out_en_n,
    output port_acc_t acc
);

    logic tok_access;

    // Purpose: qualify the token space and split it into write and read.
    always_comb begin
        tok_access = ram_sel_n & ~tok_sel_n;
        acc.wr     = tok_access & ~rnw;
        acc.rd_win = tok_access & rnw & ~out_en_n;
    end

endmodule

// File: rtl/sem_token.sv
// Module: sem_token
// One lock token with a request latch per side and an owner register.
// Latches store the last bit 0 written by each side (1 = no request).
// Ownership moves only when the holder releases; a pending request on the
// other side is served on the same edge. Same-cycle requests on a free token
// go to the left side.
// Assumes: write strobes are already qualified for this token's index.
module sem_token
    import sem_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_wr,
    input  logic l_bit,
    input  logic r_wr,
    input  logic r_bit,
    output logic flag_l,
    output logic flag_r
);

    logic   req_l_q, req_r_q;
    logic   req_l_d, req_r_d;
    owner_e own_q, own_d;

    // Purpose: next value of each side's request latch.
    always_comb begin
        req_l_d = l_wr ? l_bit : req_l_q;
        req_r_d = r_wr ? r_bit : req_r_q;
    end

    // Purpose: resolve the owner from the latches and the current holder.
    always_comb begin
        own_d = own_q;
        unique case (own_q)
            OWN_NONE: begin
                if (!req_l_d)      own_d = OWN_LEFT;
                else if (!req_r_d) own_d = OWN_RIGHT;
            end
            OWN_LEFT: begin
                if (req_l_d)       own_d = req_r_d ? OWN_NONE : OWN_RIGHT;
            end
            OWN_RIGHT: begin
                if (req_r_d)       own_d = req_l_d ? OWN_NONE : OWN_LEFT;
            end
            default:               own_d = OWN_NONE;
        endcase
    end

    // Purpose: state registers; reset leaves the token free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_l_q <= 1'b1;
            req_r_q <= 1'b1;
            own_q   <= OWN_NONE;
        end else begin
            req_l_q <= req_l_d;
            req_r_q <= req_r_d;
            own_q   <= own_d;
        end
    end

    // Purpose: flag as seen from each side (0 = this side holds it).
    always_comb begin
        flag_l = (own_q != OWN_LEFT);
        flag_r = (own_q != OWN_RIGHT);
    end

endmodule

// File: rtl/sem_read_hold.sv
// Module: sem_read_hold
// Captures the indexed flag on the first edge of a read window and keeps it
// until the window closes, so one read never shows a change in mid-access.
// Assumes: flags are registered state from the token array.
module sem_read_hold #(
    parameter int NUM_TOK = 8,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_win,
    input  logic [IDX_W-1:0]   idx,
    input  logic [NUM_TOK-1:0] flags,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid
);

    logic [DATA_W-1:0] hold_q;
    logic              open_q;

    // Purpose: track the window and capture the flag when it opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            open_q <= 1'b0;
        end else begin
            open_q <= rd_win;
            if (rd_win && !open_q) begin
                hold_q <= {DATA_W{flags[idx]}};
            end
        end
    end

    // Purpose: drive the held byte only while the read is open.
    always_comb begin
        rvalid = open_q;
        rdata  = open_q ? hold_q : '0;
    end

endmodule

// File: rtl/sem_bank.sv
// Module: sem_bank (top)
// Eight lock tokens shared by a left and a right port. Each port decodes its
// pins, strobes the token picked by its index and reads through its own
// capture register.
// Assumes: both ports share one clock; only bit 0 of write data matters.
module sem_bank
    import sem_bank_pkg::*;
#(
    parameter int NUM_TOK = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_TOK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ram_sel_n,
    input  logic              l_tok_sel_n,
    input  logic              l_rnw,
    input  logic              l_out_en_n,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              r_ram_sel_n,
    input  logic              r_tok_sel_n,
    input  logic              r_rnw,
    input  logic              r_out_en_n,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);

    port_acc_t          l_acc, r_acc;
    logic [NUM_TOK-1:0] flag_l, flag_r;
    logic               wdata_unused;

    // Purpose: upper write-data bits carry no meaning for tokens.
    assign wdata_unused = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

    sem_port_decode i_dec_l (
        .ram_sel_n (l_ram_sel_n),
        .tok_sel_n (l_tok_sel_n),
        .rnw       (l_rnw),
        .out_en_n  (l_out_en_n),
        .acc       (l_acc)
    );

    sem_port_decode i_dec_r (
        .ram_sel_n (r_ram_sel_n),
        .tok_sel_n (r_tok_sel_n),
        .rnw       (r_rnw),
        .out_en_n  (r_out_en_n),
        .acc       (r_acc)
    );

    for (genvar t = 0; t < NUM_TOK; t++) begin : g_tok
        logic l_hit, r_hit;

        // Purpose: route each port's write strobe to the indexed token.
        always_comb begin
            l_hit = l_acc.wr && (l_idx == IDX_W'(t));
            r_hit = r_acc.wr && (r_idx == IDX_W'(t));
        end

        sem_token i_tok (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_wr   (l_hit),
            .l_bit  (l_wdata[0]),
            .r_wr   (r_hit),
            .r_bit  (r_wdata[0]),
            .flag_l (flag_l[t]),
            .flag_r (flag_r[t])
        );
    end

    sem_read_hold #(
        .NUM_TOK (NUM_TOK),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) i_rd_l (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_win (l_acc.rd_win),
        .idx    (l_idx),
        .flags  (flag_l),
        .rdata  (l_rdata),
        .rvalid (l_rvalid)
    );

    sem_read_hold #(
        .NUM_TOK (NUM_TOK),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) i_rd_r (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_win (r_acc.rd_win),
        .idx    (r_idx),
        .flags  (flag_r),
        .rdata  (r_rdata),
        .rvalid (r_rvalid)
    );

endmodule

// File: rtl/sem_bank_chk.sv
// Module: sem_bank_chk
// Property checker bound to sem_bank: exclusive holding, frozen and
// replicated read data, illegal accesses and the reset state.
// Assumes: bound through the bind statement at the end of this file.
module sem_bank_chk #(
    parameter int NUM_TOK = 8,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_ram_sel_n,
    input logic               l_tok_sel_n,
    input logic               l_rnw,
    input logic               r_ram_sel_n,
    input logic               r_tok_sel_n,
    input logic               r_rnw,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               l_rvalid,
    input logic [DATA_W-1:0]  r_rdata,
    input logic               r_rvalid,
    input logic [NUM_TOK-1:0] flag_l,
    input logic [NUM_TOK-1:0] flag_r
);

    logic rst_q;
    logic l_bad, r_bad, l_wr_ok, r_wr_ok;

    // Purpose: remember the previous reset level to spot reset release.
    always_ff @(posedge clk) rst_q <= rst_n;

    // Purpose: port-level decode of illegal and legal write accesses.
    always_comb begin
        l_bad   = !l_ram_sel_n && !l_tok_sel_n;
        r_bad   = !r_ram_sel_n && !r_tok_sel_n;
        l_wr_ok = l_ram_sel_n && !l_tok_sel_n && !l_rnw;
        r_wr_ok = r_ram_sel_n && !r_tok_sel_n && !r_rnw;
    end

    AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_l | flag_r) == {NUM_TOK{1'b1}}); // R3

    AST_LRD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rvalid && $past(l_rvalid)) |-> $stable(l_rdata)); // R6

    AST_RRD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rvalid && $past(r_rvalid)) |-> $stable(r_rdata)); // R6

    AST_LRD_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
        l_rvalid |-> (l_rdata == '0 || l_rdata == '1)); // R5

    AST_RRD_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
        r_rvalid |-> (r_rdata == '0 || r_rdata == '1)); // R5

    AST_LBAD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        l_bad |=> !l_rvalid); // R9

    AST_BAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (l_bad && !r_wr_ok) || (r_bad && !l_wr_ok) || (l_bad && r_bad)
        |=> ($stable(flag_l) && $stable(flag_r))); // R9

    AST_RESET_FREE: assert property (@(posedge clk)
        (rst_n && !rst_q) |-> (&flag_l && &flag_r && !l_rvalid && !r_rvalid)); // R10

endmodule

bind sem_bank sem_bank_chk #(
    .NUM_TOK (NUM_TOK),
    .DATA_W  (DATA_W)
) i_sem_bank_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .l_ram_sel_n (l_ram_sel_n),
    .l_tok_sel_n (l_tok_sel_n),
    .l_rnw       (l_rnw),
    .r_ram_sel_n (r_ram_sel_n),
    .r_tok_sel_n (r_tok_sel_n),
    .r_rnw       (r_rnw),
    .l_rdata     (l_rdata),
    .l_rvalid    (l_rvalid),
    .r_rdata     (r_rdata),
    .r_rvalid    (r_rvalid),
    .flag_l      (flag_l),
    .flag_r      (flag_r)
);

// File: tb/test_sem_bank.sv
// Bench for sem_bank: directed corner cases, then seeded random traffic,
// checked against a behavioural model kept in bench functions.
module test_sem_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_ram_sel_n, l_tok_sel_n, l_rnw, l_out_en_n;
    logic [2:0] l_idx;
    logic [7:0] l_wdata, l_rdata;
    logic       l_rvalid;
    logic       r_ram_sel_n, r_tok_sel_n, r_rnw, r_out_en_n;
    logic [2:0] r_idx;
    logic [7:0] r_wdata, r_rdata;
    logic       r_rvalid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bit mreq_l [NT];
    bit mreq_r [NT];
    int mown   [NT];   // 0 free, 1 left, 2 right

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank i_sem_bank (
        .clk(clk), .rst_n(rst_n),
        .l_ram_sel_n(l_ram_sel_n), .l_tok_sel_n(l_tok_sel_n), .l_rnw(l_rnw),
        .l_out_en_n(l_out_en_n), .l_idx(l_idx), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .r_ram_sel_n(r_ram_sel_n), .r_tok_sel_n(r_tok_sel_n), .r_rnw(r_rnw),
        .r_out_en_n(r_out_en_n), .r_idx(r_idx), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_rvalid(r_rvalid)
    );

    function automatic bit mflag(int side, int t);
        return (mown[t] == side + 1) ? 1'b0 : 1'b1;
    endfunction

    // Model of one clock edge: latch updates, then owner resolution.
    function automatic void mstep(bit lw, int li, bit lb, bit rw, int ri, bit rb);
        if (lw) mreq_l[li] = lb;
        if (rw) mreq_r[ri] = rb;
        for (int t = 0; t < NT; t++) begin
            if (mown[t] == 0) begin
                if (!mreq_l[t]) mown[t] = 1;
                else if (!mreq_r[t]) mown[t] = 2;
            end else if (mown[t] == 1 && mreq_l[t]) begin
                mown[t] = mreq_r[t] ? 0 : 2;
            end else if (mown[t] == 2 && mreq_r[t]) begin
                mown[t] = mreq_l[t] ? 0 : 1;
            end
        end
    endfunction

    task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        l_ram_sel_n = 1; l_tok_sel_n = 1; l_rnw = 1; l_out_en_n = 1;
        r_ram_sel_n = 1; r_tok_sel_n = 1; r_rnw = 1; r_out_en_n = 1;
    endtask

    // Drive one cycle of writes; mode per side: 0 idle, 1 write, 2 illegal.
    task automatic wr2(int lm, int li, logic [7:0] ld, int rm, int ri, logic [7:0] rd);
        idle();
        l_idx = 3'(li); l_wdata = ld; r_idx = 3'(ri); r_wdata = rd;
        if (lm == 1) begin l_tok_sel_n = 0; l_rnw = 0; end
        if (lm == 2) begin l_ram_sel_n = 0; l_tok_sel_n = 0; l_rnw = 0; end
        if (rm == 1) begin r_tok_sel_n = 0; r_rnw = 0; end
        if (rm == 2) begin r_ram_sel_n = 0; r_tok_sel_n = 0; r_rnw = 0; end
        cyc();
        mstep(lm == 1, li, ld[0], rm == 1, ri, rd[0]);
        idle();
    endtask

    // Open a read, check the captured byte, close it, check valid drops.
    task automatic rd_chk(int side, int t, bit exp, string tag);
        idle();
        if (side == 0) begin l_tok_sel_n = 0; l_out_en_n = 0; l_idx = 3'(t); end
        else           begin r_tok_sel_n = 0; r_out_en_n = 0; r_idx = 3'(t); end
        cyc();
        if (side == 0) begin
            chk(l_rvalid === 1'b1 && l_rdata === {8{exp}}, tag, l_rdata, {8{exp}});
        end else begin
            chk(r_rvalid === 1'b1 && r_rdata === {8{exp}}, tag, r_rdata, {8{exp}});
        end
        idle();
        cyc();
        chk((side == 0 ? l_rvalid : r_rvalid) === 1'b0, {tag, " R6 valid drop"},
            8'(side == 0 ? l_rvalid : r_rvalid), 8'h00);
    endtask

    task automatic sweep(string tag);
        for (int t = 0; t < NT; t++) begin
            rd_chk(0, t, mflag(0, t), tag);
            rd_chk(1, t, mflag(1, t), tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int t = 0; t < NT; t++) begin mreq_l[t] = 1; mreq_r[t] = 1; mown[t] = 0; end
        idle();
        l_idx = 0; r_idx = 0; l_wdata = 0; r_wdata = 0;
        repeat (3) cyc();
        chk(l_rvalid === 1'b0 && r_rvalid === 1'b0, "R10 rvalid in reset",
            {6'd0, l_rvalid, r_rvalid}, 8'h00);
        rst_n = 1;
        cyc();
        // R10: every token free on both sides
        sweep("R10 reset free");

        // R2 with R5: 0xFE requests token 3 for the left side
        wr2(1, 3, 8'hFE, 0, 0, 8'h00);
        rd_chk(0, 3, 0, "R2 left holds");
        rd_chk(1, 3, 1, "R2 right sees taken");
        // R1: neighbours untouched
        rd_chk(0, 2, 1, "R1 idx2 untouched");
        rd_chk(0, 4, 1, "R1 idx4 untouched");

        // R3: right cannot take or release a held token
        wr2(0, 0, 8'h00, 1, 3, 8'hFF);
        rd_chk(0, 3, 0, "R3 non-holder one ignored");
        wr2(0, 0, 8'h00, 1, 3, 8'h00);
        rd_chk(0, 3, 0, "R3 left still holds");
        rd_chk(1, 3, 1, "R3 right still waits");

        // R4: left release with right pending hands it over at once
        wr2(1, 3, 8'h01, 0, 0, 8'h00);
        rd_chk(1, 3, 0, "R4 right took over");
        rd_chk(0, 3, 1, "R4 left released");

        // R8: left pends, right releases -> left, not free; then left frees
        wr2(1, 3, 8'h00, 0, 0, 8'h00);
        wr2(0, 0, 8'h00, 1, 3, 8'h01);
        rd_chk(0, 3, 0, "R8 passed back not free");
        rd_chk(1, 3, 1, "R8 right sees held");
        wr2(1, 3, 8'hFF, 0, 0, 8'h00);
        rd_chk(0, 3, 1, "R8 free left");
        rd_chk(1, 3, 1, "R8 free right");

        // R7: same-cycle requests on token 5 go left
        wr2(1, 5, 8'h00, 1, 5, 8'h00);
        rd_chk(0, 5, 0, "R7 left wins tie");
        rd_chk(1, 5, 1, "R7 right loses tie");

        // R6: right read held open across a handover keeps its old value
        wr2(0, 0, 8'h00, 1, 5, 8'h00);
        idle();
        r_tok_sel_n = 0; r_out_en_n = 0; r_idx = 3'd5;
        cyc();
        chk(r_rvalid === 1'b1 && r_rdata === 8'hFF, "R6 first capture", r_rdata, 8'hFF);
        l_tok_sel_n = 0; l_rnw = 0; l_idx = 3'd5; l_wdata = 8'h01;
        cyc();
        mstep(1, 5, 1, 0, 0, 0);
        l_tok_sel_n = 1; l_rnw = 1;
        cyc();
        chk(r_rdata === 8'hFF, "R6 frozen during open read", r_rdata, 8'hFF);
        idle();
        cyc();
        rd_chk(1, 5, 0, "R6 reopen sees new owner");

        // R9: illegal access on free token 7 writes nothing, reads nothing
        wr2(2, 7, 8'h00, 2, 7, 8'h00);
        rd_chk(0, 7, 1, "R9 illegal write ignored left");
        rd_chk(1, 7, 1, "R9 illegal write ignored right");
        idle();
        l_ram_sel_n = 0; l_tok_sel_n = 0; l_out_en_n = 0;
        cyc();
        chk(l_rvalid === 1'b0 && l_rdata === 8'h00, "R9 illegal read", l_rdata, 8'h00);
        idle();
        cyc();

        // Random traffic with periodic full sweeps
        for (int it = 0; it < 400; it++) begin
            int lm, rm;
            lm = ($urandom % 4 == 0) ? 2 : int'($urandom % 2);
            rm = ($urandom % 4 == 0) ? 2 : int'($urandom % 2);
            wr2(lm, int'($urandom % NT), 8'($urandom), rm, int'($urandom % NT), 8'($urandom));
            if (it % 20 == 19) sweep("R1 R3 R4 R8 random sweep");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule